// File: doc/BRIEF.md
# Pipelined AES Column Mixer with Round-Key Addition

This unit applies the forward-cipher column mixing step of AES to a stream of 32-bit state columns and then XORs a 32-bit round-key word onto each result. It accepts one column per clock cycle, qualified by a valid flag, and produces one finished column per cycle, six cycles later. The mixing uses a rewritten form: each output byte is the GF(2^8) doubling of the XOR of two neighbouring input bytes, combined by XOR with the three remaining byte terms. The doubling is built from a shift, a mask, a small multiply and an XOR. Every stage is a register, so the unit takes a new column on every cycle.

A per-column last-round flag skips the mixing, so only the key XOR is applied. The four key bytes and the three doubling constants (shift amount, mask and reduction polynomial) sit in a small byte-wide register file that the host writes. Each column takes a snapshot of these registers when it enters. A host write therefore never changes a column that is already inside the pipeline. Byte substitution, row shifting, key expansion and the inverse transform are handled elsewhere.

Top module: `aes_mixkey_pipe`

## Requirements
- R1: After reset, `out_valid` is 0. The register file holds key bytes 0x00, shift 0x07, mask 0x01 and polynomial 0x1B.
- R2: Byte x0 is `in_col[31:24]`, x1 is `[23:16]`, x2 is `[15:8]` and x3 is `[7:0]`. Output bytes y0..y3 sit in `out_col` in the same positions.
- R3: When `in_last`=0, y_i = D(x_i ^ x_(i+1)) ^ x_(i+1) ^ x_(i+2) ^ x_(i+3) ^ K_i, with indices taken mod 4. With default constants and a zero key, column db 13 53 45 becomes 8e 4d a1 bc.
- R4: The doubling is D(v) = ((v<<1) ^ (((v>>S) & M) * P)) truncated to 8 bits. S, M and P are the register file values at addresses 4, 5 and 6, so writing other values changes the result accordingly.
- R5: Key bytes K0..K3 are held at register addresses 0..3. Each is XORed onto output byte y0..y3 respectively.
- R6: When `in_last`=1, the mixing is skipped and y_i = x_i ^ K_i.
- R7: `out_valid` is high exactly six cycles after `in_valid` was high, and low otherwise. Back-to-back columns come out back to back.
- R8: A register write made in cycle n affects only columns presented after cycle n. A column presented in the same cycle as the write, or earlier, uses the old values.
- R9: A write to address 7 has no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input column is valid this cycle |
| in_last | input | 1 | Final-round column: skip the mixing |
| in_col | input | 32 | Input state column, x0 in the top byte |
| cfg_we | input | 1 | Register file write strobe |
| cfg_addr | input | 3 | Register address (0-3 key bytes, 4 shift, 5 mask, 6 polynomial) |
| cfg_wdata | input | 8 | Register write data |
| out_valid | output | 1 | Output column is valid |
| out_col | output | 32 | Mixed and keyed column, y0 in the top byte |

## Verification
The bench targets several failure modes, each with its own symptom.
- Byte rotation and lane order. A lane wired to the wrong neighbour garbles the known-answer column and scrambles every random column.
- Inputs with the top bit set after the pairwise XOR. A fault in the shift, mask or polynomial path shows up only on these bytes.
- Non-default shift, mask and polynomial values. A design with hard-coded constants ignores these writes and keeps producing standard results.
- Key writes in the same cycle as a column, and during a column burst. A design that reads the live key at the last stage, instead of the snapshot taken at entry, puts the new key onto columns already in flight.
- Last-round columns mixed in among normal ones. These expose a bypass that is mistimed or applied to the wrong column.

// File: rtl/aes_mk_pkg.sv
package aes_mk_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_SHIFT = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_MASK  = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_POLY  = 3'd6;

    localparam logic [BYTE_W-1:0] RST_SHIFT = 8'h07;
    localparam logic [BYTE_W-1:0] RST_MASK  = 8'h01;
    localparam logic [BYTE_W-1:0] RST_POLY  = 8'h1B;

    typedef struct packed {
        logic              last;
        logic [WORD_W-1:0] key;
        logic [BYTE_W-1:0] shamt;
        logic [BYTE_W-1:0] mask;
        logic [BYTE_W-1:0] poly;
    } side_t;
endpackage

// File: rtl/aes_mk_cfg.sv
module aes_mk_cfg
    import aes_mk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [WORD_W-1:0] key_word,
    output logic [BYTE_W-1:0] shamt,
    output logic [BYTE_W-1:0] mask,
    output logic [BYTE_W-1:0] poly
);
    logic [BYTE_W-1:0] key_q [LANES];
    logic [BYTE_W-1:0] sh_q, mk_q, pl_q;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_key
            always_ff @(posedge clk) begin
                if (!rst_n)
                    key_q[i] <= '0;
                else if (we && addr == ADDR_W'(i))
                    key_q[i] <= wdata;
            end
            assign key_word[(LANES-1-i)*BYTE_W +: BYTE_W] = key_q[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= RST_SHIFT;
            mk_q <= RST_MASK;
            pl_q <= RST_POLY;
        end else if (we) begin
            case (addr)
                ADDR_SHIFT: sh_q <= wdata;
                ADDR_MASK:  mk_q <= wdata;
                ADDR_POLY:  pl_q <= wdata;
                default:    ;
            endcase
        end
    end

    assign shamt = sh_q;
    assign mask  = mk_q;
    assign poly  = pl_q;
endmodule

// File: rtl/aes_mk_lane.sv
module aes_mk_lane
    import aes_mk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] xa,
    input  logic [BYTE_W-1:0] xb,
    input  logic [BYTE_W-1:0] xc,
    input  logic [BYTE_W-1:0] xd,
    input  logic [BYTE_W-1:0] shamt_s2,
    input  logic [BYTE_W-1:0] mask_s2,
    input  logic [BYTE_W-1:0] poly_s3,
    input  logic              last_s5,
    input  logic [BYTE_W-1:0] key_s5,
    output logic [BYTE_W-1:0] y
);
    localparam int PROD_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] pair_q, tri_q, own2_q;
    logic [BYTE_W-1:0] sl_q, hi_q, tri3_q, own3_q;
    logic [BYTE_W-1:0] red_q, sl4_q, tri4_q, own4_q;
    logic [BYTE_W-1:0] dbl_q, tri5_q, own5_q;
    logic [BYTE_W-1:0] y_q;
    logic [PROD_W-1:0] prod;

    assign prod = PROD_W'(hi_q) * PROD_W'(poly_s3);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '0; tri_q <= '0; own2_q <= '0;
            sl_q   <= '0; hi_q  <= '0; tri3_q <= '0; own3_q <= '0;
            red_q  <= '0; sl4_q <= '0; tri4_q <= '0; own4_q <= '0;
            dbl_q  <= '0; tri5_q <= '0; own5_q <= '0;
            y_q    <= '0;
        end else begin
            pair_q <= xa ^ xb;
            tri_q  <= xb ^ (xc ^ xd);
            own2_q <= xa;
            sl_q   <= pair_q << 1;
            hi_q   <= (pair_q >> shamt_s2) & mask_s2;
            tri3_q <= tri_q;
            own3_q <= own2_q;
            red_q  <= prod[BYTE_W-1:0];
            sl4_q  <= sl_q;
            tri4_q <= tri3_q;
            own4_q <= own3_q;
            dbl_q  <= sl4_q ^ red_q;
            tri5_q <= tri4_q;
            own5_q <= own4_q;
            y_q    <= (last_s5 ? own5_q : (dbl_q ^ tri5_q)) ^ key_s5;
        end
    end

    assign y = y_q;
endmodule

// File: rtl/aes_mixkey_pipe.sv
module aes_mixkey_pipe
    import aes_mk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_last,
    input  logic [31:0] in_col,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic        out_valid,
    output logic [31:0] out_col
);
    localparam int DEPTH = 6;

    logic [WORD_W-1:0] key_word;
    logic [BYTE_W-1:0] cfg_sh, cfg_mk, cfg_pl;
    logic [WORD_W-1:0] col_q;
    logic              vld_q [1:DEPTH];
    side_t             side_q [1:DEPTH-1];
    side_t             side_in;

    aes_mk_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .key_word (key_word),
        .shamt    (cfg_sh),
        .mask     (cfg_mk),
        .poly     (cfg_pl)
    );

    assign side_in = '{last: in_last, key: key_word, shamt: cfg_sh,
                       mask: cfg_mk, poly: cfg_pl};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            for (int s = 1; s <= DEPTH; s++) vld_q[s] <= 1'b0;
            for (int s = 1; s < DEPTH; s++)  side_q[s] <= '0;
        end else begin
            col_q     <= in_col;
            vld_q[1]  <= in_valid;
            side_q[1] <= side_in;
            for (int s = 2; s <= DEPTH; s++) vld_q[s] <= vld_q[s-1];
            for (int s = 2; s < DEPTH; s++)  side_q[s] <= side_q[s-1];
        end
    end

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            localparam int PA = (LANES-1-i) * BYTE_W;
            localparam int PB = (LANES-1-((i+1)%LANES)) * BYTE_W;
            localparam int PC = (LANES-1-((i+2)%LANES)) * BYTE_W;
            localparam int PD = (LANES-1-((i+3)%LANES)) * BYTE_W;
            aes_mk_lane u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .xa       (col_q[PA +: BYTE_W]),
                .xb       (col_q[PB +: BYTE_W]),
                .xc       (col_q[PC +: BYTE_W]),
                .xd       (col_q[PD +: BYTE_W]),
                .shamt_s2 (side_q[2].shamt),
                .mask_s2  (side_q[2].mask),
                .poly_s3  (side_q[3].poly),
                .last_s5  (side_q[5].last),
                .key_s5   (side_q[5].key[PA +: BYTE_W]),
                .y        (out_col[PA +: BYTE_W])
            );
        end
    endgenerate

    assign out_valid = vld_q[DEPTH];
endmodule

// File: rtl/aes_mixkey_chk.sv
module aes_mixkey_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_last,
    input logic [31:0] in_col,
    input logic [31:0] key_w,
    input logic [7:0]  sh_w,
    input logic [7:0]  mk_w,
    input logic [7:0]  pl_w,
    input logic        out_valid,
    input logic [31:0] out_col
);
    function automatic logic [7:0] dbl(input logic [7:0] v);
        return {v[6:0], 1'b0} ^ (v[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [31:0] std_mix(input logic [31:0] c);
        logic [7:0] x [4];
        logic [31:0] r;
        for (int i = 0; i < 4; i++) x[i] = c[(3-i)*8 +: 8];
        for (int i = 0; i < 4; i++)
            r[(3-i)*8 +: 8] = dbl(x[i] ^ x[(i+1)%4]) ^ x[(i+1)%4]
                              ^ x[(i+2)%4] ^ x[(i+3)%4];
        return r;
    endfunction

    // R7: output valid only six cycles after an input valid
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 6));

    // R6: last-round column carries only the key it saw on entry
    a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_last, 6)) |->
            out_col == ($past(in_col, 6) ^ $past(key_w, 6)));

    // R3: with standard constants, output is the standard column mix plus key
    a_r3_mix: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_last, 6) && $past(sh_w, 6) == 8'h07 &&
         $past(mk_w, 6) == 8'h01 && $past(pl_w, 6) == 8'h1B) |->
            out_col == (std_mix($past(in_col, 6)) ^ $past(key_w, 6)));

    // R1: valid never unknown once out of reset
    a_r1_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(out_valid));
endmodule

bind aes_mixkey_pipe aes_mixkey_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_col    (in_col),
    .key_w     (key_word),
    .sh_w      (cfg_sh),
    .mk_w      (cfg_mk),
    .pl_w      (cfg_pl),
    .out_valid (out_valid),
    .out_col   (out_col)
);

// File: tb/aes_mixkey_pipe_tb_top.sv
`timescale 1ns/1ps
module aes_mixkey_pipe_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [31:0] in_col = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        out_valid;
    logic [31:0] out_col;

    int n_run = 0, n_bad = 0, cyc = 0;
    logic        ev [16];
    logic [31:0] ed [16];
    string       etag [16];
    logic [7:0]  m_key [4];
    logic [7:0]  m_sh, m_mk, m_pl;

    always #2 clk = ~clk;

    aes_mixkey_pipe dut_i (.*);

    function automatic logic [31:0] ref_col(input logic [31:0] c, input logic last);
        logic [7:0] x [4];
        logic [7:0] t;
        logic [15:0] p;
        logic [31:0] r;
        for (int i = 0; i < 4; i++) x[i] = c[(3-i)*8 +: 8];
        for (int i = 0; i < 4; i++) begin
            if (last) r[(3-i)*8 +: 8] = x[i] ^ m_key[i];
            else begin
                t = x[i] ^ x[(i+1)%4];
                p = 16'((t >> m_sh) & m_mk) * 16'(m_pl);
                r[(3-i)*8 +: 8] = (8'(t << 1) ^ p[7:0]) ^ x[(i+1)%4]
                                  ^ x[(i+2)%4] ^ x[(i+3)%4] ^ m_key[i];
            end
        end
        return r;
    endfunction

    function automatic void check(input string tag, input logic [31:0] act,
                                  input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    // One cycle: check outputs due now, then drive inputs (at negedge)
    task automatic step(input logic v, input logic last, input logic [31:0] c,
                        input string tag, input logic we = 1'b0,
                        input logic [2:0] a = 3'd0, input logic [7:0] d = 8'h00);
        int k = cyc % 16, k6 = (cyc + 6) % 16;
        check({etag[k], " valid (R7)"}, {31'b0, out_valid}, {31'b0, ev[k]});
        if (ev[k]) check(etag[k], out_col, ed[k]);
        ev[k] = 1'b0;
        in_valid = v; in_last = last; in_col = c;
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        ev[k6] = v; ed[k6] = ref_col(c, last); etag[k6] = tag;
        if (we) begin   // R8: model updates after this cycle's column
            case (a)
                3'd4: m_sh = d;
                3'd5: m_mk = d;
                3'd6: m_pl = d;
                3'd7: ;                      // R9: no register here
                default: m_key[a] = d;
            endcase
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 32'h0, "idle");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin ev[i] = 1'b0; ed[i] = '0; etag[i] = ""; end
        for (int i = 0; i < 4; i++) m_key[i] = 8'h00;
        m_sh = 8'h07; m_mk = 8'h01; m_pl = 8'h1B;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'b0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {31'b0, out_valid}, 32'd0);
        // R3/R1: known answer with reset constants and zero key
        step(1'b1, 1'b0, 32'hdb135345, "R3 known answer");
        ed[(cyc + 5) % 16] = 32'h8e4da1bc;   // literal expectation, not model
        step(1'b1, 1'b0, 32'h00000000, "R2 zero column");
        step(1'b1, 1'b0, 32'hf20a225c, "R2 byte order");
        step(1'b1, 1'b0, 32'hffffffff, "R4 high bits");
        idle(7);
        // R5: key bytes, write same cycle as column (R8)
        step(1'b1, 1'b0, 32'h01010101, "R8 same-cycle write", 1'b1, 3'd0, 8'hA5);
        step(1'b1, 1'b0, 32'h01010101, "R5 key byte 0", 1'b1, 3'd1, 8'h3C);
        step(1'b1, 1'b0, 32'hc6c6c6c6, "R5 key byte 1", 1'b1, 3'd2, 8'h0F);
        step(1'b1, 1'b0, 32'hd4d4d4d5, "R5 key byte 2", 1'b1, 3'd3, 8'h81);
        step(1'b1, 1'b0, 32'h2d26314c, "R5 all keys");
        step(1'b1, 1'b1, 32'h2d26314c, "R6 last round");
        step(1'b1, 1'b0, 32'h80402010, "R6 then mix");
        step(1'b1, 1'b1, 32'hdeadbeef, "R6 last again", 1'b1, 3'd7, 8'hFF);
        step(1'b1, 1'b0, 32'hdeadbeef, "R9 addr 7 ignored");
        idle(7);
        // R4: alternative constants
        step(1'b1, 1'b0, 32'h8f1e7733, "R4 poly change", 1'b1, 3'd6, 8'h00);
        step(1'b1, 1'b0, 32'h8f1e7733, "R4 poly zero", 1'b1, 3'd6, 8'h4D);
        step(1'b1, 1'b0, 32'h8f1e7733, "R4 poly 4D", 1'b1, 3'd4, 8'h06);
        step(1'b1, 1'b0, 32'hc3a5f00f, "R4 shift 6", 1'b1, 3'd5, 8'h03);
        step(1'b1, 1'b0, 32'hc3a5f00f, "R4 mask 3");
        step(1'b1, 1'b0, 32'hc3a5f00f, "R4 restore", 1'b1, 3'd4, 8'h07);
        step(1'b1, 1'b0, 32'hc3a5f00f, "R4 restore", 1'b1, 3'd5, 8'h01);
        step(1'b1, 1'b0, 32'hc3a5f00f, "R4 restore", 1'b1, 3'd6, 8'h1B);
        idle(7);
        // Random stream: R3 R6 R7 R8
        begin
            int seed = 1234;
            void'($urandom(seed));
        end
        for (int i = 0; i < 400; i++) begin
            logic v = ($urandom % 4) != 0;
            logic l = ($urandom % 5) == 0;
            logic w = ($urandom % 6) == 0;
            logic [2:0] a = 3'($urandom % 4);
            step(v, l, $urandom, "R3 random", w, a, 8'($urandom));
        end
        idle(8);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule